// File: doc/BRIEF.md
# Register-Register Execute Unit with Split-Halfword Add

This block is the purely combinational arithmetic stage for register-to-register instructions of a 32-bit processor core. Two operand words and the two function fields of the instruction (a 3-bit minor code and a 7-bit major code) go in. The selected 32-bit result comes out in the same cycle.

The unit covers the following operations:
- addition and subtraction;
- logical shifts in both directions;
- signed compare-less-than;
- the three bitwise logic operations;
- the low product word;
- the signed and unsigned high product words;
- unsigned quotient and unsigned remainder;
- a split add, which sums the two 16-bit halves of the operands separately.

The surrounding core handles the register file, immediates and opcode decoding. It feeds this unit only when the instruction is of register-register form.

Top module: `rr_exec_unit`

## Requirements
- R1: With minor code 0x0, major code 0x00 gives A+B and major code 0x20 gives A-B, both modulo 2^32.
- R2: Minor code 0x0 with major code 0x0F is the split add. Result bits 15:0 are A[15:0]+B[15:0] mod 2^16, and bits 31:16 are A[31:16]+B[31:16] mod 2^16. No carry crosses bit 15: 0x0001FFFF and 0x00010005 give 0x00020004.
- R3: Minor code 0x0 with major code 0x01 gives bits 31:0 of the product A*B.
- R4: Major code 0x01 selects a high product word. Minor code 0x1 gives bits 63:32 of the signed-by-signed product, and minor code 0x3 gives bits 63:32 of the unsigned-by-unsigned product.
- R5: With major code 0x00, minor code 0x1 shifts A left and minor code 0x5 shifts A right, filling with zeros. In both cases the shift distance is B[4:0] and the higher bits of B are ignored.
- R6: Minor code 0x2 with major code 0x00 returns 1 when A is less than B as two's-complement values, and 0 otherwise.
- R7: With major code 0x00, minor code 0x4 gives A xor B, 0x6 gives A or B, and 0x7 gives A and B.
- R8: With major code 0x01, minor code 0x5 gives the unsigned quotient A/B and minor code 0x7 gives the unsigned remainder A%B.
- R9: When B is zero, the quotient is 0xFFFFFFFF and the remainder equals A.
- R10: Any pairing of minor and major code not listed above yields 0x00000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 32 | First operand (dividend, shifted value) |
| op_b | input | 32 | Second operand (divisor, shift distance in bits 4:0) |
| fn_minor | input | 3 | Minor function code of the instruction |
| fn_major | input | 7 | Major function code of the instruction |
| result | output | 32 | Selected result word |

## Verification
Random operand pairs go through every listed code pairing. Random code pairs also appear, which shows that unlisted pairings are forced to zero rather than aliased onto a neighbour.

Directed cases each target a specific confusion:
- Halves that overflow distinguish the split add from a plain 32-bit add.
- Negative operands distinguish the signed high product and compare from their unsigned versions.
- Shift operands with high bits set show whether only five bits are used as the distance.
- A zero divisor shows the defined quotient and remainder values.

// File: rtl/rr_exec_unit.sv
module rr_exec_unit #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  input  logic [2:0]    fn_minor,
  input  logic [6:0]    fn_major,
  output logic [DW-1:0] result
);
  localparam int HW = DW / 2;
  localparam int SW = $clog2(DW);
  localparam logic [6:0] MJ_BASE = 7'h00;
  localparam logic [6:0] MJ_MULT = 7'h01;
  localparam logic [6:0] MJ_SPLT = 7'h0F;
  localparam logic [6:0] MJ_NEG  = 7'h20;

  logic [2*DW-1:0] prod_uu, prod_ss;
  logic [DW-1:0]   ext_a, ext_b;
  logic [SW-1:0]   shamt;
  logic [HW-1:0]   sum_lo, sum_hi;
  logic [DW-1:0]   quot, rem;
  logic            lt_signed;

  assign ext_a   = {DW{op_a[DW-1]}};
  assign ext_b   = {DW{op_b[DW-1]}};
  assign prod_uu = {{DW{1'b0}}, op_a} * {{DW{1'b0}}, op_b};
  assign prod_ss = {ext_a, op_a} * {ext_b, op_b};
  assign shamt   = op_b[SW-1:0];
  assign sum_lo  = op_a[HW-1:0] + op_b[HW-1:0];
  assign sum_hi  = op_a[DW-1:HW] + op_b[DW-1:HW];
  assign quot    = (op_b == '0) ? '1   : op_a / op_b;
  assign rem     = (op_b == '0) ? op_a : op_a % op_b;
  assign lt_signed = $signed(op_a) < $signed(op_b);

  always_comb begin
    result = '0;
    unique case (fn_major)
      MJ_BASE: begin
        unique case (fn_minor)
          3'h0: result = op_a + op_b;
          3'h1: result = op_a << shamt;
          3'h2: result = {{(DW-1){1'b0}}, lt_signed};
          3'h4: result = op_a ^ op_b;
          3'h5: result = op_a >> shamt;
          3'h6: result = op_a | op_b;
          3'h7: result = op_a & op_b;
          default: result = '0;
        endcase
      end
      MJ_MULT: begin
        unique case (fn_minor)
          3'h0: result = prod_uu[DW-1:0];
          3'h1: result = prod_ss[2*DW-1:DW];
          3'h3: result = prod_uu[2*DW-1:DW];
          3'h5: result = quot;
          3'h7: result = rem;
          default: result = '0;
        endcase
      end
      MJ_SPLT: result = (fn_minor == 3'h0) ? {sum_hi, sum_lo} : '0;
      MJ_NEG:  result = (fn_minor == 3'h0) ? op_a - op_b : '0;
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/rr_exec_unit_chk.sv
module rr_exec_unit_chk #(
  parameter int DW = 32
) (
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic [2:0]    fn_minor,
  input logic [6:0]    fn_major,
  input logic [DW-1:0] result
);
  localparam int HW = DW / 2;

  function automatic logic listed(input logic [6:0] mj, input logic [2:0] mn);
    case ({mj, mn})
      {7'h00, 3'h0}, {7'h00, 3'h1}, {7'h00, 3'h2}, {7'h00, 3'h4},
      {7'h00, 3'h5}, {7'h00, 3'h6}, {7'h00, 3'h7},
      {7'h01, 3'h0}, {7'h01, 3'h1}, {7'h01, 3'h3}, {7'h01, 3'h5},
      {7'h01, 3'h7}, {7'h0F, 3'h0}, {7'h20, 3'h0}: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic [HW-1:0] lo_ref, hi_ref;
  assign lo_ref = op_a[HW-1:0] + op_b[HW-1:0];
  assign hi_ref = op_a[DW-1:HW] + op_b[DW-1:HW];

  always_comb begin
    if (fn_major == 7'h0F && fn_minor == 3'h0) begin
      a_r2_split_low:  assert (result[HW-1:0] == lo_ref);
      a_r2_split_high: assert (result[DW-1:HW] == hi_ref);
    end
    if (fn_major == 7'h00 && fn_minor == 3'h2)
      a_r6_cmp_is_bit: assert (result[DW-1:1] == '0);
    if (fn_major == 7'h01 && fn_minor == 3'h5 && op_b == '0)
      a_r9_div_zero: assert (result == '1);
    if (fn_major == 7'h01 && fn_minor == 3'h7 && op_b == '0)
      a_r9_rem_zero: assert (result == op_a);
    if (!listed(fn_major, fn_minor))
      a_r10_unlisted_zero: assert (result == '0);
  end
endmodule

bind rr_exec_unit rr_exec_unit_chk #(.DW(DW)) chk_i (
  .op_a(op_a), .op_b(op_b), .fn_minor(fn_minor),
  .fn_major(fn_major), .result(result)
);

// File: tb/rr_exec_unit_tb_top.sv
`timescale 1ns/1ps
module rr_exec_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] a, b;
  logic [2:0]  mn;
  logic [6:0]  mj;
  logic [31:0] res;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  rr_exec_unit dut_i (.op_a(a), .op_b(b), .fn_minor(mn), .fn_major(mj), .result(res));

  function automatic logic [31:0] model(input logic [31:0] x, input logic [31:0] y,
                                        input logic [2:0] f3, input logic [6:0] f7);
    longint sx, sy, sp;
    logic [63:0] up;
    logic [15:0] l, h;
    sx = longint'($signed(x));
    sy = longint'($signed(y));
    sp = sx * sy;
    up = {32'd0, x} * {32'd0, y};
    l = x[15:0] + y[15:0];
    h = x[31:16] + y[31:16];
    if (f7 == 7'h00 && f3 == 3'h0) return x + y;                         // R1
    if (f7 == 7'h20 && f3 == 3'h0) return x - y;                         // R1
    if (f7 == 7'h0F && f3 == 3'h0) return {h, l};                        // R2
    if (f7 == 7'h01 && f3 == 3'h0) return up[31:0];                      // R3
    if (f7 == 7'h01 && f3 == 3'h1) return sp[63:32];                     // R4
    if (f7 == 7'h01 && f3 == 3'h3) return up[63:32];                     // R4
    if (f7 == 7'h00 && f3 == 3'h1) return x << y[4:0];                   // R5
    if (f7 == 7'h00 && f3 == 3'h5) return x >> y[4:0];                   // R5
    if (f7 == 7'h00 && f3 == 3'h2) return (sx < sy) ? 32'd1 : 32'd0;    // R6
    if (f7 == 7'h00 && f3 == 3'h4) return x ^ y;                         // R7
    if (f7 == 7'h00 && f3 == 3'h6) return x | y;                         // R7
    if (f7 == 7'h00 && f3 == 3'h7) return x & y;                         // R7
    if (f7 == 7'h01 && f3 == 3'h5) return (y == 0) ? 32'hFFFF_FFFF : x / y; // R8 R9
    if (f7 == 7'h01 && f3 == 3'h7) return (y == 0) ? x : x % y;             // R8 R9
    return 32'd0;                                                        // R10
  endfunction

  function automatic string tag_of(input logic [2:0] f3, input logic [6:0] f7);
    case ({f7, f3})
      {7'h00, 3'h0}, {7'h20, 3'h0}: return "R1";
      {7'h0F, 3'h0}: return "R2";
      {7'h01, 3'h0}: return "R3";
      {7'h01, 3'h1}, {7'h01, 3'h3}: return "R4";
      {7'h00, 3'h1}, {7'h00, 3'h5}: return "R5";
      {7'h00, 3'h2}: return "R6";
      {7'h00, 3'h4}, {7'h00, 3'h6}, {7'h00, 3'h7}: return "R7";
      {7'h01, 3'h5}, {7'h01, 3'h7}: return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic run(input logic [31:0] x, input logic [31:0] y,
                     input logic [2:0] f3, input logic [6:0] f7, input string tag);
    logic [31:0] exp;
    @(negedge clk);
    a = x; b = y; mn = f3; mj = f7;
    exp = model(x, y, f3, f7);
    @(posedge clk); #1;
    n_run++;
    if (res !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h f3=%h f7=%h got=%h exp=%h", tag, x, y, f3, f7, res, exp);
    end
  endtask

  task automatic op_pick(input int k, output logic [2:0] f3, output logic [6:0] f7);
    case (k)
      0: begin f7 = 7'h00; f3 = 3'h0; end
      1: begin f7 = 7'h20; f3 = 3'h0; end
      2: begin f7 = 7'h0F; f3 = 3'h0; end
      3: begin f7 = 7'h01; f3 = 3'h0; end
      4: begin f7 = 7'h01; f3 = 3'h1; end
      5: begin f7 = 7'h01; f3 = 3'h3; end
      6: begin f7 = 7'h00; f3 = 3'h1; end
      7: begin f7 = 7'h00; f3 = 3'h5; end
      8: begin f7 = 7'h00; f3 = 3'h2; end
      9: begin f7 = 7'h00; f3 = 3'h4; end
      10: begin f7 = 7'h00; f3 = 3'h6; end
      11: begin f7 = 7'h00; f3 = 3'h7; end
      12: begin f7 = 7'h01; f3 = 3'h5; end
      default: begin f7 = 7'h01; f3 = 3'h7; end
    endcase
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] f3;
    logic [6:0] f7;
    logic [31:0] x, y;
    void'($urandom(32'd1234));
    a = '0; b = '0; mn = '0; mj = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_run++;
    if (res !== 32'd0) begin
      n_fail++;
      $display("FAIL R1 reset-state got=%h exp=00000000", res);
    end

    run(32'h7FFF_FFFF, 32'h1,        3'h0, 7'h00, "R1 add wrap");
    run(32'h0,         32'h1,        3'h0, 7'h20, "R1 sub borrow");
    run(32'h0001_FFFF, 32'h0001_0005, 3'h0, 7'h0F, "R2 split carry");
    run(32'h0001_0003, 32'h0005_0002, 3'h0, 7'h0F, "R2 split plain");
    run(32'hFFFF_FFFF, 32'h0001_0001, 3'h0, 7'h0F, "R2 both wrap");
    run(32'h1234_5678, 32'h9ABC_DEF0, 3'h0, 7'h01, "R3 mul low");
    run(32'h8000_0000, 32'h8000_0000, 3'h1, 7'h01, "R4 mulh min*min");
    run(32'hFFFF_FFFF, 32'h0000_0002, 3'h1, 7'h01, "R4 mulh neg");
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'h3, 7'h01, "R4 mulhu max");
    run(32'h0000_0001, 32'hFFFF_FFE1, 3'h1, 7'h00, "R5 sll high bits ignored");
    run(32'h8000_0000, 32'h0000_003F, 3'h5, 7'h00, "R5 srl by 31");
    run(32'hFFFF_FFFF, 32'h0000_0001, 3'h2, 7'h00, "R6 neg<pos");
    run(32'h0000_0001, 32'hFFFF_FFFF, 3'h2, 7'h00, "R6 pos>neg");
    run(32'h0000_0005, 32'h0000_0005, 3'h2, 7'h00, "R6 equal");
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 3'h4, 7'h00, "R7 xor");
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 3'h6, 7'h00, "R7 or");
    run(32'hF0F0_F0F0, 32'hFF00_FF00, 3'h7, 7'h00, "R7 and");
    run(32'd100,       32'd7,        3'h5, 7'h01, "R8 divu");
    run(32'd100,       32'd7,        3'h7, 7'h01, "R8 remu");
    run(32'h8000_0000, 32'h0,        3'h5, 7'h01, "R9 div by zero");
    run(32'hDEAD_BEEF, 32'h0,        3'h7, 7'h01, "R9 rem by zero");
    run(32'hFFFF_FFFF, 32'h1,        3'h1, 7'h20, "R10 unlisted sra-like");
    run(32'hFFFF_FFFF, 32'h1,        3'h2, 7'h01, "R10 unlisted 01/2");
    run(32'hFFFF_FFFF, 32'h1,        3'h1, 7'h0F, "R10 unlisted 0F/1");

    for (int i = 0; i < 3000; i++) begin
      x = $urandom;
      y = ($urandom_range(0, 9) == 0) ? 32'd0 : $urandom;
      if ($urandom_range(0, 7) == 0) begin
        f3 = 3'($urandom);
        f7 = 7'($urandom);
      end else begin
        op_pick($urandom_range(0, 13), f3, f7);
      end
      run(x, y, f3, f7, tag_of(f3, f7));
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule